// File: doc/BRIEF.md
# Flagless Immediate Rotate-Right Execution Slice

This unit is one execution slice of a processor back end. It takes a 64-bit source operand, an 8-bit immediate rotate count, the current processor mode and two decoded prefix bits. From these it produces a rotated result, a destination write-enable, a flag-update enable and an undefined-opcode fault strobe. The unit chooses the operand width from the mode and the width prefix bit, and trims the immediate to the count range of that width. It rotates the operand right and rejects encodings or modes in which the operation is not allowed. The condition flags are never read or updated.

The slice registers its outputs, so an operation presented with `op_valid` high on one rising clock edge appears on the outputs directly after that edge. Operand fetch, address generation, register writeback and the rest of instruction decode sit outside the unit.

Top module: `rotr_noflag_unit`

## Requirements
- R1: `mode` is encoded as 0 = 64-bit mode, 1 = protected or compatibility mode, 2 = real mode, 3 = virtual-8086 mode. A valid operation in mode 2 or 3 raises `fault_ud`.
- R2: A valid operation with `pfx_l` = 1 raises `fault_ud`, whatever the mode and width bit.
- R3: Whenever `fault_ud` is high, `res_we` is low and `res_data` is zero.
- R4: In mode 1 the operand is 32 bits wide and `pfx_w` has no effect on the result.
- R5: In mode 0, `pfx_w` = 1 selects a 64-bit operand and `pfx_w` = 0 selects a 32-bit operand.
- R6: For a 32-bit operand, only bits [4:0] of `imm` form the count. Bits [31:0] of the source are rotated right within 32 bits, and `res_data[63:32]` is zero.
- R7: For a 64-bit operand, only bits [5:0] of `imm` form the count, and all 64 source bits are rotated right.
- R8: A trimmed count of zero returns the selected source bits unchanged.
- R9: `flags_we` is low in every cycle.
- R10: Outputs are registered with one cycle of latency. A legal operation sets `res_we` = 1. A cycle with `op_valid` low gives `res_we` = 0, `fault_ud` = 0 and `res_data` = 0.
- R11: While `rst` is high at a rising edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| src | input | 64 | Source operand |
| imm | input | 8 | Immediate rotate count |
| mode | input | 2 | Processor mode (0 64-bit, 1 protected/compat, 2 real, 3 virtual-8086) |
| pfx_w | input | 1 | Width prefix bit |
| pfx_l | input | 1 | Vector-length prefix bit, must be 0 |
| res_data | output | 64 | Rotated result, zero on fault or idle |
| res_we | output | 1 | Destination write-enable |
| flags_we | output | 1 | Flag-update enable, always 0 |
| fault_ud | output | 1 | Undefined-opcode fault strobe |

## Verification
A table of hand-worked cases covers several situations: a nibble-aligned rotate that separates the 32-bit and 64-bit paths, immediates with bits above the trimmed field set, which expose a wrong count mask, and a single-bit rotate that exposes an off-by-one wrap. A source with a nonzero upper half in 32-bit mode shows whether upper bits leak into the result. After the table, an exhaustive sweep runs every immediate value from 0 to 255 through every mode, width bit and length bit, each with a fresh pseudo-random source. The sweep compares the result against an index-based reference rotate, so a swapped mode decode or a wrong fault priority shows up as a mismatch. Directed steps check the reset state, the idle cycles and a reset that arrives while an operation is in flight.

// File: rtl/rotr_pkg.sv
package rotr_pkg;

  typedef enum logic [1:0] {
    MODE_LONG   = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_REAL   = 2'd2,
    MODE_V86    = 2'd3
  } cpu_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/rotr_mode_decode.sv
module rotr_mode_decode
  import rotr_pkg::*;
(
  input  logic              op_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic              pfx_w,
  input  logic              pfx_l,
  output logic              wide_sel,
  output logic              fault,
  output logic              legal
);

  cpu_mode_e mode_e;
  logic      mode_bad;

  always_comb begin
    mode_e   = cpu_mode_e'(mode);
    mode_bad = (mode_e == MODE_REAL) || (mode_e == MODE_V86);
    // width prefix only matters in 64-bit mode
    wide_sel = (mode_e == MODE_LONG) && pfx_w;
    fault    = op_valid && (mode_bad || pfx_l);
    legal    = op_valid && !mode_bad && !pfx_l;
  end

endmodule

// File: rtl/rotr_count_mask.sv
module rotr_count_mask #(
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned NCNT_W = 5
) (
  input  logic [IMM_W-1:0] imm,
  input  logic             wide_sel,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned DROP_W = CNT_W - NCNT_W;

  logic [CNT_W-1:0] mask;
  logic             unused_imm_hi;

  assign unused_imm_hi = ^imm[IMM_W-1:CNT_W];

  always_comb begin
    mask  = wide_sel ? {CNT_W{1'b1}} : {{DROP_W{1'b0}}, {NCNT_W{1'b1}}};
    count = imm[CNT_W-1:0] & mask;
  end

endmodule

// File: rtl/rotr_barrel.sv
module rotr_barrel #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stage [CNT_W+1];

  assign stage[0] = din;

  // each stage rotates right by a fixed power of two, so no shift ever
  // needs a variable amount equal to the full width
  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int unsigned AMT = 1 << s;
    always_comb begin
      if (count[s])
        stage[s+1] = {stage[s][AMT-1:0], stage[s][DATA_W-1:AMT]};
      else
        stage[s+1] = stage[s];
    end
  end

  assign dout = stage[CNT_W];

endmodule

// File: rtl/rotr_noflag_unit.sv
module rotr_noflag_unit
  import rotr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IMM_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [DATA_W-1:0]   src,
  input  logic [IMM_W-1:0]    imm,
  input  logic [MODE_W-1:0]   mode,
  input  logic                pfx_w,
  input  logic                pfx_l,
  output logic [DATA_W-1:0]   res_data,
  output logic                res_we,
  output logic                flags_we,
  output logic                fault_ud
);

  localparam int unsigned NARROW_W = DATA_W / 2;
  localparam int unsigned CNT_W    = $clog2(DATA_W);
  localparam int unsigned NCNT_W   = $clog2(NARROW_W);

  logic              wide_sel;
  logic              fault_c;
  logic              legal_c;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] rot_in;
  logic [DATA_W-1:0] rot_out;
  logic [DATA_W-1:0] result_c;

  rotr_mode_decode u_decode (
    .op_valid (op_valid),
    .mode     (mode),
    .pfx_w    (pfx_w),
    .pfx_l    (pfx_l),
    .wide_sel (wide_sel),
    .fault    (fault_c),
    .legal    (legal_c)
  );

  rotr_count_mask #(
    .IMM_W  (IMM_W),
    .CNT_W  (CNT_W),
    .NCNT_W (NCNT_W)
  ) u_mask (
    .imm      (imm),
    .wide_sel (wide_sel),
    .count    (count)
  );

  // narrow operands are doubled so the full-width rotator wraps at NARROW_W
  always_comb begin
    if (wide_sel) rot_in = src;
    else          rot_in = {src[NARROW_W-1:0], src[NARROW_W-1:0]};
  end

  rotr_barrel #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_barrel (
    .din   (rot_in),
    .count (count),
    .dout  (rot_out)
  );

  always_comb begin
    if (!legal_c)      result_c = '0;
    else if (wide_sel) result_c = rot_out;
    else               result_c = {{NARROW_W{1'b0}}, rot_out[NARROW_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data <= '0;
      res_we   <= 1'b0;
      flags_we <= 1'b0;
      fault_ud <= 1'b0;
    end else begin
      res_data <= result_c;
      res_we   <= legal_c;
      flags_we <= 1'b0;
      fault_ud <= fault_c;
    end
  end

endmodule

// File: rtl/rotr_noflag_unit_chk.sv
module rotr_noflag_unit_chk
  import rotr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IMM_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [DATA_W-1:0] src,
  input logic [IMM_W-1:0]  imm,
  input logic [MODE_W-1:0] mode,
  input logic              pfx_w,
  input logic              pfx_l,
  input logic [DATA_W-1:0] res_data,
  input logic              res_we,
  input logic              flags_we,
  input logic              fault_ud
);

  localparam int unsigned NARROW_W = DATA_W / 2;
  localparam int unsigned CNT_W    = $clog2(DATA_W);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_WE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(res_we && fault_ud)); // R3
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    fault_ud |-> (res_data == '0)); // R3
  AST_FLAGS_LOW: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> !flags_we); // R9
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_valid && (mode == MODE_REAL || mode == MODE_V86)) |-> fault_ud); // R1
  AST_L_FAULT: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_valid && pfx_l) |-> fault_ud); // R2
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_valid && mode == MODE_LEGACY)
      |-> (res_data[DATA_W-1:NARROW_W] == '0)); // R4
  AST_ZERO_CNT: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_valid && mode == MODE_LONG && pfx_w && !pfx_l
                     && imm[CNT_W-1:0] == '0)
      |-> (res_data == $past(src))); // R8
  AST_IDLE: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!op_valid) |-> (!res_we && !fault_ud && res_data == '0)); // R10

endmodule

bind rotr_noflag_unit rotr_noflag_unit_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .src      (src),
  .imm      (imm),
  .mode     (mode),
  .pfx_w    (pfx_w),
  .pfx_l    (pfx_l),
  .res_data (res_data),
  .res_we   (res_we),
  .flags_we (flags_we),
  .fault_ud (fault_ud)
);

// File: tb/rotr_noflag_unit_tb_top.sv
module rotr_noflag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [63:0] src = '0;
  logic [7:0]  imm = '0;
  logic [1:0]  mode = '0;
  logic        pfx_w = 1'b0;
  logic        pfx_l = 1'b0;
  logic [63:0] res_data;
  logic        res_we;
  logic        flags_we;
  logic        fault_ud;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  rotr_noflag_unit dut_i (
    .clk (clk), .rst (rst), .op_valid (op_valid), .src (src), .imm (imm),
    .mode (mode), .pfx_w (pfx_w), .pfx_l (pfx_l), .res_data (res_data),
    .res_we (res_we), .flags_we (flags_we), .fault_ud (fault_ud)
  );

  localparam int NV = 10;
  localparam logic [63:0] V_SRC [NV] = '{
    64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF,
    64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF,
    64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0001,
    64'hFFFF_FFFF_0000_0001};
  localparam logic [7:0]  V_IMM  [NV] = '{8'h04, 8'h04, 8'h24, 8'h44, 8'h00,
                                          8'h20, 8'h04, 8'h04, 8'h01, 8'h1F};
  localparam logic [1:0]  V_MODE [NV] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0,
                                          2'd1, 2'd2, 2'd0, 2'd0, 2'd1};
  localparam logic        V_W    [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1,
                                          1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic        V_L    [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [63:0] V_EXP  [NV] = '{
    64'hF012_3456_789A_BCDE, 64'h0000_0000_F89A_BCDE, 64'h0000_0000_F89A_BCDE,
    64'hF012_3456_789A_BCDE, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_89AB_CDEF,
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'h0000_0000_0000_0002};
  localparam logic        V_FLT  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam string       V_TAG  [NV] = '{"R7", "R5", "R4", "R7", "R8",
                                          "R6", "R1", "R2", "R7", "R6"};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_rot(logic [63:0] s, logic [7:0] k,
                                          logic [1:0] md, logic w);
    int width = (md == 2'd0 && w) ? 64 : 32;
    int c = int'(k) % width;
    logic [63:0] r = '0;
    for (int i = 0; i < width; i++) r[i] = s[(i + c) % width];
    return r;
  endfunction

  task automatic apply(logic [63:0] s, logic [7:0] k, logic [1:0] md,
                       logic w, logic l);
    @(negedge clk);
    op_valid = 1'b1; src = s; imm = k; mode = md; pfx_w = w; pfx_l = l;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic check_out(string req, logic [63:0] exp_d, logic exp_f);
    chk(req, res_data, exp_d);
    chk(req, {63'd0, res_we}, {63'd0, !exp_f});
    chk(req, {63'd0, fault_ud}, {63'd0, exp_f});
    chk("R9", {63'd0, flags_we}, 64'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs cleared by reset
    chk("R11", res_data, 64'd0);
    chk("R11", {61'd0, res_we, flags_we, fault_ud}, 64'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      apply(V_SRC[v], V_IMM[v], V_MODE[v], V_W[v], V_L[v]);
      check_out(V_TAG[v], V_EXP[v], V_FLT[v]);
    end

    // R10: idle cycle after an operation
    @(negedge clk);
    chk("R10", res_data, 64'd0);
    chk("R10", {62'd0, res_we, fault_ud}, 64'd0);

    // exhaustive sweep of count, mode, width and length bits
    for (int k = 0; k < 256; k++) begin
      for (int md = 0; md < 4; md++) begin
        for (int w = 0; w < 2; w++) begin
          for (int l = 0; l < 2; l++) begin
            logic flt;
            string tag;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            flt = (md >= 2) || (l == 1);
            if (md >= 2)                tag = "R1";
            else if (l == 1)            tag = "R2";
            else if (md == 0 && w == 1) tag = "R7";
            else if (md == 0)           tag = "R5";
            else                        tag = "R4";
            apply(lfsr, 8'(k), 2'(md), w[0], l[0]);
            check_out(tag, flt ? 64'd0 : ref_rot(lfsr, 8'(k), 2'(md), w[0]), flt);
          end
        end
      end
    end

    // R6: upper source bits ignored in 32-bit operation
    apply(64'hDEAD_BEEF_0000_0010, 8'h04, 2'd1, 1'b1, 1'b0);
    check_out("R6", 64'h0000_0000_0000_0001, 1'b0);

    // R11: reset while an operation is in flight
    @(negedge clk);
    op_valid = 1'b1; src = 64'hFFFF_FFFF_FFFF_FFFF; imm = 8'h01;
    mode = 2'd0; pfx_w = 1'b1; pfx_l = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R11", res_data, 64'd0);
    chk("R11", {62'd0, res_we, fault_ud}, 64'd0);
    op_valid = 1'b0; rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule